// File: doc/BRIEF.md
# Edge-triggered port interrupt gate

This block produces the interrupt request for a parallel I/O block. Two input pins, one per port group (the bit 3 line of each group's third port), are watched for rising edges. Each pin first passes through a synchronizer. When a rising edge is seen while the gate is enabled, a single shared pending flag is set. The pending flag drives a level interrupt request to the host.

The host controls the gate only through plain accesses inside a 16-byte register window, and the data on those accesses is ignored. A write to offset 0xB turns the gate on. A read of the same offset turns it off. A write to offset 0xF acknowledges a pending request. A two-bit status readback shows whether the gate is enabled and whether a request is pending. The host strobes are treated as single-cycle pulses, and each one takes effect on the clock edge where it is sampled.

Top module: `pio_edge_irq`

## Requirements
- R1: While reset is asserted, and on the first edge after it, `irq_req` is 0 and `status` is 0 (interrupts disabled, nothing pending).
- R2: A write strobe to offset 0xB sets the enable flag, which is `status` bit 0, on that clock edge. The data value plays no part.
- R3: A read strobe to offset 0xB clears the enable flag and the pending flag on that edge, so `irq_req` is low on the next cycle. If a write strobe to 0xB arrives in the same cycle, the enable wins.
- R4: While enabled, a rising edge on either pin sets the pending flag (`status` bit 1, also driven on `irq_req`). A pin that goes high just before clock edge k shows `irq_req` high after edge k+2. Falling edges and steady levels do not set the flag.
- R5: A rising edge that is evaluated while the gate is disabled is dropped. This includes the edge on which the enabling write lands.
- R6: Once set, `irq_req` stays high until a clear write or a disabling read.
- R7: A write strobe to offset 0xF clears the pending flag on that edge.
- R8: When a rising edge and a clear write to 0xF are evaluated on the same edge, the request stays pending.
- R9: Reads of 0xF, and reads or writes of any offset other than 0xB and 0xF, change neither `irq_req` nor `status`.
- R10: Either source pin alone is enough to raise the shared request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | NUM_SRC | Interrupt-capable pins, one per port group |
| host_addr | input | ADDR_W | Host offset within the register window |
| host_wr | input | 1 | Host write strobe, one cycle |
| host_rd | input | 1 | Host read strobe, one cycle |
| irq_req | output | 1 | Level interrupt request |
| status | output | 2 | Bit 0 is enabled, bit 1 is pending |

## Verification
Host strobes have a one-edge latency. A strobe held during the cycle before edge k shows up on `status` and `irq_req` right after edge k. Pin edges have a three-edge latency: a pin changed just before edge k is first reflected after edge k+2.

The bench drives inputs on the falling clock edge and samples outputs on the next falling edge, so every result is read half a period after the rising edge that produced it. The directed cases count ticks exactly to these latencies, including the cases where an edge collides with a clear write or an enable write. The random phase steps a cycle-accurate reference model on each rising edge and compares against it.

// File: rtl/pio_irq_pkg.sv
package pio_irq_pkg;
  localparam int unsigned STAT_W = 2;

  typedef struct packed {
    logic en_set;
    logic dis;
    logic clr;
  } pio_cmd_t;
endpackage

// File: rtl/pio_pin_sync.sv
module pio_pin_sync #(
  parameter int unsigned NUM_SRC     = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] pin_in,
  output logic [NUM_SRC-1:0] rise
);
  localparam int unsigned LAST = SYNC_STAGES - 1;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    logic [SYNC_STAGES-1:0] chain_q;
    logic                   prev_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        chain_q <= '0;
        prev_q  <= 1'b0;
      end else begin
        chain_q <= {chain_q[SYNC_STAGES-2:0], pin_in[g]};
        prev_q  <= chain_q[LAST];
      end
    end

    assign rise[g] = chain_q[LAST] & ~prev_q;
  end
endmodule

// File: rtl/pio_host_decode.sv
module pio_host_decode
  import pio_irq_pkg::*;
#(
  parameter int unsigned ADDR_W  = 4,
  parameter int unsigned EN_OFS  = 11,
  parameter int unsigned CLR_OFS = 15
) (
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_wr,
  input  logic              host_rd,
  output pio_cmd_t          cmd
);
  localparam logic [ADDR_W-1:0] EN_A  = EN_OFS[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] CLR_A = CLR_OFS[ADDR_W-1:0];

  logic hit_en;
  logic hit_clr;

  always_comb begin
    hit_en     = (host_addr == EN_A);
    hit_clr    = (host_addr == CLR_A);
    cmd.en_set = host_wr & hit_en;
    cmd.dis    = host_rd & hit_en & ~cmd.en_set;
    cmd.clr    = host_wr & hit_clr;
  end
endmodule

// File: rtl/pio_irq_state.sv
module pio_irq_state
  import pio_irq_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  pio_cmd_t cmd,
  input  logic     any_rise,
  output logic     en_q,
  output logic     pend_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      if (cmd.en_set)   en_q <= 1'b1;
      else if (cmd.dis) en_q <= 1'b0;

      if (!en_q || cmd.dis) pend_q <= 1'b0;
      else if (any_rise)    pend_q <= 1'b1;
      else if (cmd.clr)     pend_q <= 1'b0;
    end
  end
endmodule

// File: rtl/pio_edge_irq.sv
module pio_edge_irq
  import pio_irq_pkg::*;
#(
  parameter int unsigned NUM_SRC     = 2,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned ADDR_W      = 4,
  parameter int unsigned EN_OFS      = 11,
  parameter int unsigned CLR_OFS     = 15
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] pin_in,
  input  logic [ADDR_W-1:0]  host_addr,
  input  logic               host_wr,
  input  logic               host_rd,
  output logic               irq_req,
  output logic [STAT_W-1:0]  status
);
  logic [NUM_SRC-1:0] rise;
  logic               any_rise;
  pio_cmd_t           cmd;
  logic               en_q;
  logic               pend_q;

  pio_pin_sync #(
    .NUM_SRC    (NUM_SRC),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_sync (
    .clk   (clk),
    .rst   (rst),
    .pin_in(pin_in),
    .rise  (rise)
  );

  assign any_rise = |rise;

  pio_host_decode #(
    .ADDR_W (ADDR_W),
    .EN_OFS (EN_OFS),
    .CLR_OFS(CLR_OFS)
  ) u_dec (
    .host_addr(host_addr),
    .host_wr  (host_wr),
    .host_rd  (host_rd),
    .cmd      (cmd)
  );

  pio_irq_state u_state (
    .clk     (clk),
    .rst     (rst),
    .cmd     (cmd),
    .any_rise(any_rise),
    .en_q    (en_q),
    .pend_q  (pend_q)
  );

  assign irq_req = pend_q;
  assign status  = {pend_q, en_q};
endmodule

// File: rtl/pio_edge_irq_chk.sv
module pio_edge_irq_chk #(
  parameter int unsigned ADDR_W  = 4,
  parameter int unsigned EN_OFS  = 11,
  parameter int unsigned CLR_OFS = 15
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] host_addr,
  input logic              host_wr,
  input logic              host_rd,
  input logic              any_rise,
  input logic              irq_req,
  input logic [1:0]        status
);
  logic wr_en, rd_en, dis, wr_clr;
  assign wr_en  = host_wr && (host_addr == EN_OFS[ADDR_W-1:0]);
  assign rd_en  = host_rd && (host_addr == EN_OFS[ADDR_W-1:0]);
  assign dis    = rd_en && !wr_en;
  assign wr_clr = host_wr && (host_addr == CLR_OFS[ADDR_W-1:0]);

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (!irq_req && status == 2'b00));

  p_enable_r2: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> status[0]);

  p_disable_r3: assert property (@(posedge clk) disable iff (rst)
    dis |=> (!status[0] && !irq_req));

  p_latch_r4: assert property (@(posedge clk) disable iff (rst)
    (any_rise && status[0] && !dis) |=> irq_req);

  p_drop_r5: assert property (@(posedge clk) disable iff (rst)
    (!status[0] && !wr_en) |=> !irq_req);

  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (irq_req && !wr_clr && !dis) |=> irq_req);

  p_clear_r7: assert property (@(posedge clk) disable iff (rst)
    (wr_clr && !any_rise) |=> !irq_req);

  p_rise_wins_r8: assert property (@(posedge clk) disable iff (rst)
    (wr_clr && any_rise && status[0] && !dis) |=> irq_req);

  p_no_effect_r9: assert property (@(posedge clk) disable iff (rst)
    (!any_rise && !wr_en && !rd_en && !wr_clr) |=> $stable(status));
endmodule

bind pio_edge_irq pio_edge_irq_chk #(
  .ADDR_W (ADDR_W),
  .EN_OFS (EN_OFS),
  .CLR_OFS(CLR_OFS)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .host_addr(host_addr),
  .host_wr  (host_wr),
  .host_rd  (host_rd),
  .any_rise (any_rise),
  .irq_req  (irq_req),
  .status   (status)
);

// File: tb/pio_edge_irq_bench.sv
`timescale 1ns/1ps
module pio_edge_irq_bench;
  localparam logic [3:0] A_EN  = 4'hB;
  localparam logic [3:0] A_CLR = 4'hF;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] pin = 2'b00;
  logic [3:0] host_addr = 4'h0;
  logic       host_wr = 1'b0;
  logic       host_rd = 1'b0;
  logic       irq_req;
  logic [1:0] status;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  logic [1:0] m_s1 = 0, m_s2 = 0, m_prev = 0;
  logic       m_en = 0, m_pend = 0;

  always #2.5 clk = ~clk;

  pio_edge_irq u_pio_edge_irq (
    .clk      (clk),
    .rst      (rst),
    .pin_in   (pin),
    .host_addr(host_addr),
    .host_wr  (host_wr),
    .host_rd  (host_rd),
    .irq_req  (irq_req),
    .status   (status)
  );

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic next_pend(logic en, logic pend, logic dis, logic rise, logic clr);
    if (!en || dis) return 1'b0;
    if (rise) return 1'b1;
    if (clr) return 1'b0;
    return pend;
  endfunction

  task automatic model_step();
    logic [1:0] r;
    logic es, ds, cl;
    if (rst) begin
      m_s1 = 0; m_s2 = 0; m_prev = 0; m_en = 0; m_pend = 0;
    end else begin
      r  = m_s2 & ~m_prev;
      es = host_wr && host_addr == A_EN;
      ds = host_rd && host_addr == A_EN && !es;
      cl = host_wr && host_addr == A_CLR;
      m_pend = next_pend(m_en, m_pend, ds, |r, cl);
      m_en   = es ? 1'b1 : (ds ? 1'b0 : m_en);
      m_prev = m_s2;
      m_s2   = m_s1;
      m_s1   = pin;
    end
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
  endtask

  task automatic idle();
    host_wr = 1'b0; host_rd = 1'b0; host_addr = 4'h0;
  endtask

  task automatic access(logic wr, logic rd, logic [3:0] a);
    host_wr = wr; host_rd = rd; host_addr = a;
    tick();
    idle();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd24680));
    @(negedge clk);
    // R1 reset state
    repeat (3) tick();
    check("R1 irq", irq_req, 0);
    check("R1 status", status, 0);
    rst = 1'b0;
    tick();
    check("R1 after release", status, 0);

    // R5 edge while disabled
    pin[0] = 1'b1; repeat (4) tick();
    check("R5 disabled edge", irq_req, 0);
    pin[0] = 1'b0; repeat (3) tick();

    // R2 enable
    access(1, 0, A_EN);
    check("R2 enabled", status, 1);

    // R4 latency: high after third edge
    pin[0] = 1'b1;
    tick(); check("R4 edge k", irq_req, 0);
    tick(); check("R4 edge k+1", irq_req, 0);
    tick(); check("R4 edge k+2", irq_req, 1);
    check("R4 status", status, 3);

    // R6 hold across falling edge
    pin[0] = 1'b0; repeat (6) tick();
    check("R6 held", irq_req, 1);

    // R7 clear
    access(1, 0, A_CLR);
    check("R7 cleared", irq_req, 0);
    check("R7 status", status, 1);

    // R10 second source
    pin[1] = 1'b1; repeat (3) tick();
    check("R10 source 1", irq_req, 1);

    // R9 other accesses
    access(0, 1, A_CLR);
    access(1, 0, 4'h3);
    access(0, 1, 4'h3);
    access(1, 0, 4'h7);
    check("R9 irq kept", irq_req, 1);
    check("R9 status kept", status, 3);

    // R8 rise coincides with clear
    access(1, 0, A_CLR);
    check("R7 clear again", irq_req, 0);
    pin[1] = 1'b0; repeat (3) tick();
    check("R4 falling ignored", irq_req, 0);
    pin[1] = 1'b1; tick(); tick();
    access(1, 0, A_CLR);
    check("R8 rise wins", irq_req, 1);
    access(1, 0, A_CLR);
    check("R7 clear after R8", irq_req, 0);

    // R3 disable clears pending
    pin[0] = 1'b1; repeat (3) tick();
    check("R3 precondition", irq_req, 1);
    access(0, 1, A_EN);
    check("R3 irq low", irq_req, 0);
    check("R3 status", status, 0);

    // R5 edge on enabling edge is dropped
    pin[0] = 1'b0; repeat (3) tick();
    pin[0] = 1'b1; tick(); tick();
    access(1, 0, A_EN);
    check("R5 enable edge status", status, 1);
    repeat (3) tick();
    check("R5 enable edge dropped", irq_req, 0);

    // R3 write wins over read at same offset
    access(0, 1, A_EN);
    check("R3 disabled", status, 0);
    access(1, 1, A_EN);
    check("R3 write wins", status, 1);

    // random phase against reference model
    for (int i = 0; i < 4000; i++) begin
      int unsigned r;
      r = $urandom % 16;
      idle();
      case (r)
        0, 1, 2: begin host_wr = 1; host_addr = A_EN; end
        3:       begin host_rd = 1; host_addr = A_EN; end
        4, 5, 6: begin host_wr = 1; host_addr = A_CLR; end
        7:       begin host_rd = 1; host_addr = A_CLR; end
        8:       begin host_wr = 1; host_addr = 4'($urandom); end
        9:       begin host_rd = 1; host_addr = 4'($urandom); end
        10:      begin host_wr = 1; host_rd = 1; host_addr = A_EN; end
        default: ;
      endcase
      for (int b = 0; b < 2; b++)
        if ($urandom % 4 == 0) pin[b] = ~pin[b];
      tick();
      check("R4 random irq", irq_req, m_pend);
      check("R2 random status", status, {m_pend, m_en});
    end
    idle();
    finish_run();
  end
endmodule